// File: doc/BRIEF.md
# Serial Audio Data Transmitter

This block turns a stereo pair of 24-bit two's complement samples into a single serial data line for a stereo audio link. A bit clock and a word-select signal are supplied from outside the block as plain inputs. Both are sampled by the block's system clock and must be synchronous to it. Each falling edge of the bit clock starts one bit slot. Each change of the word-select level starts a new half-frame, either left or right.

Two framing formats are offered. In the first format, word-select high marks the left half. The most significant bit goes out in the slot that begins at the word-select change. In the second format, word-select low marks the left half. The first slot of each half is sent low, and the most significant bit follows one slot later. A width select sends only the upper 16 bits of each word, for links that run 32 bit slots per frame.

Samples come in on a one-cycle valid strobe and are stored as a pending pair. The pending pair becomes the active pair only at the start of a left half. A word is therefore never replaced while it is being shifted out. While the asynchronous active-low reset is held, the data line stays low.

Top module: `serial_audio_tx`

## Requirements
- R1: While rst_n is low, sdata is low, including the cycle in which reset is asserted in the middle of a frame.
- R2: sdata changes only on the system clock edge at which a bit-clock falling edge is first seen. That is, the edge where bclk is sampled low after being sampled high. It holds its value through the rest of the slot.
- R3: With fmt_sel = 0, lrck = 1 marks the left half. In the slot that starts at the lrck change, sdata carries bit 23 of the word. The following slots carry bits 22, 21 and onward, MSB first.
- R4: With fmt_sel = 1, lrck = 0 marks the left half. The slot that starts at the lrck change is sent low. Bit 23 is sent in the next slot, followed by the lower bits in descending order.
- R5: Once the last bit of the word has been sent, every remaining slot of that half-frame is sent low.
- R6: With short16 = 1, only bits 23 down to 8 of each word are sent, in the same alignment as the selected format. All later slots of the half are low.
- R7: A change of lrck always restarts the shifter with the next channel's word. Bits that did not fit into the previous half are dropped. An example is the LSB in format 1 with 24 slots per half.
- R8: A pair presented with sample_valid is sent starting at the next left-half start. A strobe during a frame leaves that frame's words unchanged. A frame with no new strobe repeats the last pair.
- R9: The first bit-clock falling edge after reset starts a half-frame. Before any strobe, the words sent are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset (power-down), released synchronously |
| bclk | input | 1 | Bit clock, synchronous to clk; each falling edge starts a slot |
| lrck | input | 1 | Word-select; a level change starts a half-frame |
| fmt_sel | input | 1 | 0: MSB aligned, lrck high = left; 1: MSB one slot late, lrck low = left |
| short16 | input | 1 | 1: send the upper 16 bits of each word only |
| sample_valid | input | 1 | One-cycle strobe that stores left_in and right_in as the pending pair |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data line |

## Verification
The assertions assume the following about the inputs:
- bclk and lrck are synchronous to clk.
- lrck changes only together with a bclk falling edge.
- fmt_sel and short16 stay fixed between resets.
- sample_valid is never raised in the same cycle that starts a left half.

The bench keeps to these assumptions. Every bit-clock slot lasts four system cycles, with lrck driven at the falling edge. The format and width are set only while reset is held. Strobes are issued only while the bit clock is high.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic {
    FMT_MSB_ALIGNED = 1'b0,
    FMT_DELAYED     = 1'b1
  } fmt_e;

  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_SHORT_W  = 16;
  localparam int unsigned DEF_SYNC_W   = 2;

endpackage

// File: rtl/atx_edge.sv
module atx_edge
  import serial_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrck,
  input  logic fmt_sel,
  output logic slot_tick,
  output logic half_start,
  output logic left_start
);

  logic bclk_q, bclk_n;
  logic lr_q, lr_n;
  logic primed_q, primed_n;
  logic left_lvl;

  assign slot_tick  = bclk_q & ~bclk;
  assign half_start = slot_tick & (~primed_q | (lrck != lr_q));
  assign left_lvl   = (fmt_e'(fmt_sel) == FMT_DELAYED) ? 1'b0 : 1'b1;
  assign left_start = half_start & (lrck == left_lvl);

  always_comb begin
    bclk_n   = bclk;
    lr_n     = lr_q;
    primed_n = primed_q;
    if (slot_tick) begin
      lr_n     = lrck;
      primed_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      bclk_q   <= bclk_n;
      lr_q     <= lr_n;
      primed_q <= primed_n;
    end
  end

endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] l_in,
  input  logic [W-1:0] r_in,
  input  logic         take,
  output logic [W-1:0] pend_l,
  output logic [W-1:0] pend_r,
  output logic [W-1:0] act_l,
  output logic [W-1:0] act_r
);

  logic [W-1:0] pend_l_n, pend_r_n, act_l_n, act_r_n;

  always_comb begin
    pend_l_n = pend_l;
    pend_r_n = pend_r;
    act_l_n  = act_l;
    act_r_n  = act_r;
    if (load) begin
      pend_l_n = l_in;
      pend_r_n = r_in;
    end
    if (take) begin
      act_l_n = pend_l;
      act_r_n = pend_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
    end else begin
      pend_l <= pend_l_n;
      pend_r <= pend_r_n;
      act_l  <= act_l_n;
      act_r  <= act_r_n;
    end
  end

endmodule

// File: rtl/atx_shift.sv
module atx_shift
  import serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic                fmt_sel,
  input  logic                short16,
  input  logic [SAMPLE_W-1:0] word,
  output logic                sdata
);

  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

  logic [SAMPLE_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                sd_n;
  logic [CNT_W-1:0]    len;

  assign len = short16 ? LEN_SHORT : LEN_FULL;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    sd_n  = sdata;
    if (start) begin
      if (fmt_e'(fmt_sel) == FMT_MSB_ALIGNED) begin
        sd_n  = word[SAMPLE_W-1];
        sh_n  = {word[SAMPLE_W-2:0], 1'b0};
        cnt_n = len - 1'b1;
      end else begin
        sd_n  = 1'b0;
        sh_n  = word;
        cnt_n = len;
      end
    end else if (tick) begin
      if (cnt_q != '0) begin
        sd_n  = sh_q[SAMPLE_W-1];
        sh_n  = {sh_q[SAMPLE_W-2:0], 1'b0};
        cnt_n = cnt_q - 1'b1;
      end else begin
        sd_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdata <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      sdata <= sd_n;
    end
  end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SHORT_W  = DEF_SHORT_W,
  parameter int unsigned SYNC_W   = DEF_SYNC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                lrck,
  input  logic                fmt_sel,
  input  logic                short16,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata
);

  logic [SYNC_W-1:0]   rst_sync;
  logic                rst_int_n;
  logic                slot_tick, half_start, left_start;
  logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r;
  logic [SAMPLE_W-1:0] word;

  generate
    if (SYNC_W == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync <= '0;
        else        rst_sync <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync <= '0;
        else        rst_sync <= {rst_sync[SYNC_W-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync[SYNC_W-1];

  atx_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bclk       (bclk),
    .lrck       (lrck),
    .fmt_sel    (fmt_sel),
    .slot_tick  (slot_tick),
    .half_start (half_start),
    .left_start (left_start)
  );

  atx_hold #(.W(SAMPLE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (sample_valid),
    .l_in   (left_in),
    .r_in   (right_in),
    .take   (left_start),
    .pend_l (pend_l),
    .pend_r (pend_r),
    .act_l  (act_l),
    .act_r  (act_r)
  );

  assign word = left_start ? pend_l : act_r;

  atx_shift #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (slot_tick),
    .start   (half_start),
    .fmt_sel (fmt_sel),
    .short16 (short16),
    .word    (word),
    .sdata   (sdata)
  );

endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bclk,
  input logic         fmt_sel,
  input logic         sdata,
  input logic         half_start,
  input logic         left_start,
  input logic [W-1:0] pend_l,
  input logic [W-1:0] act_l
);

  // R1: data line low during reset
  assert_idle_low_R1: assert property (@(posedge clk) !rst_n |-> !sdata)
    else $error("R1 sdata high in reset");

  // R2: data changes only after a detected bit-clock fall
  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> ($past(bclk, 2) && !$past(bclk)))
    else $error("R2 sdata changed away from a bclk fall");

  // R3: aligned format puts the pending MSB out at left start
  assert_msb_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (left_start && !fmt_sel) |=> (sdata == $past(pend_l[W-1])))
    else $error("R3 MSB not aligned");

  // R4: delayed format sends a low first slot
  assert_delay_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_start && fmt_sel) |=> !sdata)
    else $error("R4 first slot not low");

  // R8: active words change only at a left-half start
  assert_latch_at_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_l) |-> $past(left_start))
    else $error("R8 active word changed mid-frame");

endmodule

bind serial_audio_tx atx_checker #(.W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk       (bclk),
  .fmt_sel    (fmt_sel),
  .sdata      (sdata),
  .half_start (half_start),
  .left_start (left_start),
  .pend_l     (pend_l),
  .act_l      (act_l)
);

// File: tb/tb_serial_audio_tx.sv
`timescale 1ns/1ps
module tb_serial_audio_tx;

  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        lrck;
  logic        fmt_sel;
  logic        short16;
  logic        sample_valid;
  logic [23:0] left_in;
  logic [23:0] right_in;
  logic        sdata;

  int checks = 0;
  int errors = 0;
  int glitches = 0;

  serial_audio_tx dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk         (bclk),
    .lrck         (lrck),
    .fmt_sel      (fmt_sel),
    .short16      (short16),
    .sample_valid (sample_valid),
    .left_in      (left_in),
    .right_in     (right_in),
    .sdata        (sdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_half(input logic [23:0] w, input int n);
    logic [63:0] v;
    int width;
    int d;
    v = '0;
    width = short16 ? 16 : 24;
    d = fmt_sel ? 1 : 0;
    for (int k = 0; k < n; k++) begin
      if (k - d >= 0 && k - d < width) v[k] = w[23 - (k - d)];
    end
    return v;
  endfunction

  task automatic do_reset(input logic f, input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sdata == 1'b0, "R1 reset asserted", {63'd0, sdata}, 64'd0);
    fmt_sel = f;
    short16 = s;
    bclk = 1'b1;
    lrck = f ? 1'b0 : 1'b1;
    sample_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    sample_valid = 1'b1;
    left_in = l;
    right_in = r;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic slot(input logic lvl, output logic b);
    logic s2;
    @(negedge clk);
    bclk = 1'b0;
    lrck = lvl;
    @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    b = sdata;
    @(negedge clk);
    s2 = sdata;
    if (s2 !== b) glitches++;
  endtask

  task automatic run_frame(input int n, input int strobe_slot,
                           input logic [23:0] nl, input logic [23:0] nr,
                           input logic [23:0] el, input logic [23:0] er,
                           input string tag);
    logic [63:0] capl, capr, e;
    logic b;
    logic left_lvl;
    capl = '0;
    capr = '0;
    glitches = 0;
    left_lvl = fmt_sel ? 1'b0 : 1'b1;
    for (int k = 0; k < n; k++) begin
      slot(left_lvl, b);
      capl[k] = b;
      if (k == strobe_slot) load_pair(nl, nr);
    end
    for (int k = 0; k < n; k++) begin
      slot(~left_lvl, b);
      capr[k] = b;
    end
    e = exp_half(el, n);
    chk(capl == e, {tag, " left"}, capl, e);
    e = exp_half(er, n);
    chk(capr == e, {tag, " right"}, capr, e);
    chk(glitches == 0, "R2 stable within slot", 64'(glitches), 64'd0);
  endtask

  task automatic t_idle;
    logic b;
    do_reset(1'b0, 1'b0);
    run_frame(32, -1, '0, '0, 24'h0, 24'h0, "R9 zero before strobe");
    load_pair(24'hFFFFFF, 24'hFFFFFF);
    run_frame(32, -1, '0, '0, 24'hFFFFFF, 24'hFFFFFF, "R3 all ones");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sdata == 1'b0, "R1 reset mid-frame", {63'd0, sdata}, 64'd0);
    glitches = 0;
    for (int k = 0; k < 4; k++) begin
      slot(k[0], b);
      chk(b == 1'b0, "R1 held in reset", {63'd0, b}, 64'd0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_fmt0_64;
    do_reset(1'b0, 1'b0);
    load_pair(24'h9A5C3F, 24'h1234E7);
    run_frame(32, -1, '0, '0, 24'h9A5C3F, 24'h1234E7, "R3 R5 fmt0 64 f1");
    run_frame(32, -1, '0, '0, 24'h9A5C3F, 24'h1234E7, "R3 R5 fmt0 64 f2");
  endtask

  task automatic t_fmt1_64;
    do_reset(1'b1, 1'b0);
    load_pair(24'h7FFFFF, 24'h800001);
    run_frame(32, -1, '0, '0, 24'h7FFFFF, 24'h800001, "R4 R5 fmt1 64 f1");
    run_frame(32, -1, '0, '0, 24'h7FFFFF, 24'h800001, "R4 R5 fmt1 64 f2");
  endtask

  task automatic t_48;
    do_reset(1'b0, 1'b0);
    load_pair(24'hC0FFEE, 24'h0F0F81);
    run_frame(24, -1, '0, '0, 24'hC0FFEE, 24'h0F0F81, "R3 fmt0 48");
    do_reset(1'b1, 1'b0);
    load_pair(24'hC0FFEF, 24'h0F0F81);
    run_frame(24, -1, '0, '0, 24'hC0FFEF, 24'h0F0F81, "R7 fmt1 48 LSB dropped");
  endtask

  task automatic t_short32;
    do_reset(1'b0, 1'b1);
    load_pair(24'hA1B2C3, 24'h5D6E7F);
    run_frame(16, -1, '0, '0, 24'hA1B2C3, 24'h5D6E7F, "R6 fmt0 32");
    do_reset(1'b1, 1'b1);
    load_pair(24'hA1B2C3, 24'h5D6E7F);
    run_frame(16, -1, '0, '0, 24'hA1B2C3, 24'h5D6E7F, "R6 R7 fmt1 32");
    do_reset(1'b0, 1'b1);
    load_pair(24'h8001FF, 24'h7FFE00);
    run_frame(32, -1, '0, '0, 24'h8001FF, 24'h7FFE00, "R6 R5 fmt0 64 short");
  endtask

  task automatic t_latch;
    do_reset(1'b1, 1'b0);
    load_pair(24'h13579B, 24'h2468AC);
    run_frame(32, 5, 24'hDEC0DE, 24'h0BEEF1, 24'h13579B, 24'h2468AC, "R8 mid-frame strobe");
    run_frame(32, -1, '0, '0, 24'hDEC0DE, 24'h0BEEF1, "R8 new pair next frame");
    run_frame(32, -1, '0, '0, 24'hDEC0DE, 24'h0BEEF1, "R8 repeat pair");
  endtask

  initial begin
    rst_n = 1'b0;
    bclk = 1'b1;
    lrck = 1'b1;
    fmt_sel = 1'b0;
    short16 = 1'b0;
    sample_valid = 1'b0;
    left_in = '0;
    right_in = '0;
    repeat (3) @(negedge clk);
    chk(sdata == 1'b0, "R1 initial reset", {63'd0, sdata}, 64'd0);
    rst_n = 1'b1;
    t_idle();
    t_fmt0_64();
    t_fmt1_64();
    t_48();
    t_short32();
    t_latch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule